// File: doc/BRIEF.md
# Line Voltage Monitor with Polarity Interrupt

The monitor receives signed line-voltage samples, each qualified by a valid strobe, and holds the most recent one as an 8-bit two's-complement status value. Each LSB is 1 V. Samples outside the 8-bit range saturate to the nearest limit. While forcing is enabled, any reading whose magnitude is at most 3 V is reported as zero. A control bit turns the forcing off so that small readings pass through unchanged.

The sign bit of the reported value gives the polarity of the line. Any change of that bit sets a sticky polarity flag, which software clears by writing 0. The interrupt output is high while the flag is set and both the global enable and the polarity mask are set. The hook state enters as a plain input and has no effect on reporting.

A small write port sets the control bits and clears the flag. The control bits and the flag are also driven on ports so that a host can read them.

Top module: `line_volt_mon`

## Requirements
- R1: After reset, volt_o, pol_flag_o, ctrl_o and irq_o are all zero.
- R2: On a clock edge with meas_valid_i high, volt_o takes the input sample at 1 V per LSB as an 8-bit two's-complement value, saturated to -128..127. Without meas_valid_i, volt_o holds its value.
- R3: With ctrl_o[2] (force-zero disable) at 0, a sample whose magnitude is 3 or less is reported as 0, for both signs.
- R4: With ctrl_o[2] at 1, small non-zero samples are reported as they are, and a 0 sample is still reported as 0.
- R5: pol_flag_o is set on the edge where bit 7 of volt_o changes, in either direction. A forced-zero update counts as a change.
- R6: A write to address 1 with data bit 0 at 0 clears pol_flag_o on the next edge. Writing 1 to that bit has no effect.
- R7: When a sign change and a clear write happen on the same edge, the flag is set.
- R8: irq_o equals pol_flag_o AND ctrl_o[0] (global enable) AND ctrl_o[1] (polarity mask), with no extra delay.
- R9: A write to address 0 loads ctrl_o from data bits 2:0 on the next edge: bit 0 is the global enable, bit 1 the mask, bit 2 the forcing disable. Higher data bits are ignored. The disable bit takes effect from the next sample edge.
- R10: off_hook_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_valid_i | input | 1 | Strobe that qualifies a sample |
| meas_i | input | MEAS_W (10) | Signed line-voltage sample, 1 V per LSB |
| off_hook_i | input | 1 | Hook state (ignored) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 status |
| wr_data_i | input | 8 | Write data |
| volt_o | output | 8 | Reported line voltage, two's complement |
| pol_flag_o | output | 1 | Sticky polarity flag |
| ctrl_o | output | 3 | Control bits {force-zero disable, mask, enable} |
| irq_o | output | 1 | Active-high interrupt |

## Verification
If the stored sign or the flag state is wrong inside the block, pol_flag_o shows it one edge after the sample that should have flipped polarity, and irq_o shows it in the same cycle whenever the enable and the mask are both set. A wrong saturation or dead-band decision shows on volt_o one edge after the valid strobe. The bench compares every output against a behavioural model on every cycle, so any divergence is caught within one clock. The same-edge set-and-clear case and the zero-reading case are driven on purpose, since the wrong priority or a wrong band edge would otherwise go unseen.

// File: rtl/lvm_pkg.sv
package lvm_pkg;
  localparam int VOLT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = 8;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;

  typedef struct packed {
    logic fz_dis;    // bit 2
    logic pol_mask;  // bit 1
    logic irq_en;    // bit 0
  } ctrl_t;
endpackage

// File: rtl/lvm_shape.sv
module lvm_shape #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8,
  parameter int DEAD  = 3
) (
  input  logic signed [IN_W-1:0]  meas_i,
  input  logic                    fz_dis_i,
  output logic signed [OUT_W-1:0] val_o
);
  localparam int MAXV = (1 << (OUT_W-1)) - 1;
  localparam int MINV = -(1 << (OUT_W-1));
  localparam logic signed [OUT_W-1:0] DB_HI = DEAD[OUT_W-1:0];
  localparam int DEAD_N = -DEAD;
  localparam logic signed [OUT_W-1:0] DB_LO = DEAD_N[OUT_W-1:0];

  logic signed [OUT_W-1:0] sat;

  generate
    if (IN_W > OUT_W) begin : g_sat
      localparam logic signed [IN_W-1:0] HI = MAXV[IN_W-1:0];
      localparam logic signed [IN_W-1:0] LO = MINV[IN_W-1:0];
      always_comb begin
        if (meas_i > HI)      sat = HI[OUT_W-1:0];
        else if (meas_i < LO) sat = LO[OUT_W-1:0];
        else                  sat = meas_i[OUT_W-1:0];
      end
    end else begin : g_pass
      assign sat = OUT_W'(meas_i);
    end
  endgenerate

  logic in_band;
  assign in_band = (sat >= DB_LO) && (sat <= DB_HI);
  assign val_o   = (!fz_dis_i && in_band) ? '0 : sat;
endmodule

// File: rtl/lvm_regs.sv
module lvm_regs
  import lvm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pol_set_i,
  output ctrl_t             ctrl_o,
  output logic              pol_flag_o
);
  logic ctrl_we, clr_req;
  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_req = wr_en_i && (wr_addr_i == ADDR_STAT) && !wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_o <= '0;
    else if (ctrl_we) ctrl_o <= ctrl_t'(wr_data_i[2:0]);
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pol_flag_o <= 1'b0;
    else if (pol_set_i) pol_flag_o <= 1'b1;
    else if (clr_req)   pol_flag_o <= 1'b0;
  end
endmodule

// File: rtl/line_volt_mon.sv
module line_volt_mon
  import lvm_pkg::*;
#(
  parameter int MEAS_W = 10,
  parameter int DEAD   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_valid_i,
  input  logic [MEAS_W-1:0] meas_i,
  input  logic              off_hook_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [VOLT_W-1:0] volt_o,
  output logic              pol_flag_o,
  output logic [2:0]        ctrl_o,
  output logic              irq_o
);
  logic unused_hook;
  assign unused_hook = off_hook_i;

  ctrl_t ctrl;
  logic signed [VOLT_W-1:0] shaped;
  logic [VOLT_W-1:0] volt_q;
  logic pol_set;

  lvm_shape #(.IN_W(MEAS_W), .OUT_W(VOLT_W), .DEAD(DEAD)) u_shape (
    .meas_i   ($signed(meas_i)),
    .fz_dis_i (ctrl.fz_dis),
    .val_o    (shaped)
  );

  assign pol_set = meas_valid_i && (shaped[VOLT_W-1] != volt_q[VOLT_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           volt_q <= '0;
    else if (meas_valid_i) volt_q <= shaped;
  end

  lvm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pol_set_i  (pol_set),
    .ctrl_o     (ctrl),
    .pol_flag_o (pol_flag_o)
  );

  assign volt_o = volt_q;
  assign ctrl_o = ctrl;
  assign irq_o  = pol_flag_o & ctrl.irq_en & ctrl.pol_mask;
endmodule

// File: rtl/lvm_chk.sv
module lvm_chk #(
  parameter int MEAS_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              meas_valid_i,
  input logic [MEAS_W-1:0] meas_i,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        volt_o,
  input logic              pol_flag_o,
  input logic [2:0]        ctrl_o,
  input logic              irq_o
);
  logic unused_meas;
  assign unused_meas = ^meas_i;

  // R2
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_valid_i |=> $stable(volt_o));

  // R3
  a_r3_dead_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && !ctrl_o[2]) |=>
      !($signed(volt_o) >= -8'sd3 && $signed(volt_o) <= 8'sd3 && volt_o != 8'd0));

  // R5
  a_r5_sign_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (volt_o[7] != $past(volt_o[7])) |-> pol_flag_o);

  // R5
  a_r5_rise_needs_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pol_flag_o) |-> $past(meas_valid_i));

  // R6
  a_r6_fall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pol_flag_o) |-> $past(wr_en_i && wr_addr_i == 2'd1 && !wr_data_i[0]));

  // R8
  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pol_flag_o && ctrl_o[0] && ctrl_o[1]));

  // R9
  a_r9_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == 2'd0) |=> $stable(ctrl_o));
endmodule

bind line_volt_mon lvm_chk #(.MEAS_W(MEAS_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .meas_valid_i (meas_valid_i),
  .meas_i       (meas_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .volt_o       (volt_o),
  .pol_flag_o   (pol_flag_o),
  .ctrl_o       (ctrl_o),
  .irq_o        (irq_o)
);

// File: tb/tb_line_volt_mon.sv
`timescale 1ns/1ps
module tb_line_volt_mon;
  localparam int MW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, hook = 1'b0, we = 1'b0;
  logic [MW-1:0] m = '0;
  logic [1:0] wa = '0;
  logic [7:0] wd = '0;
  logic [7:0] volt;
  logic flag, irq;
  logic [2:0] ctrl;

  always #2 clk = ~clk;

  line_volt_mon dut (
    .clk_i(clk), .rst_ni(rst_n), .meas_valid_i(v), .meas_i(m),
    .off_hook_i(hook), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .volt_o(volt), .pol_flag_o(flag), .ctrl_o(ctrl), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int  r_volt = 0;
  bit  r_flag = 0;
  int  r_ctrl = 0;

  function automatic int shape(int x, bit dis);
    int s;
    s = (x > 127) ? 127 : (x < -128) ? -128 : x;
    if (!dis && s >= -3 && s <= 3) s = 0;
    return s;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic cmp(string tag);
    chk(tag, "volt", int'($signed(volt)), r_volt);
    chk(tag, "flag", int'(flag), int'(r_flag));
    chk(tag, "ctrl", int'(ctrl), r_ctrl);
    chk(tag, "irq",  int'(irq), int'(r_flag && r_ctrl[0] && r_ctrl[1]));
  endtask

  // drive after negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit vi, int mi, bit wi, int ai, int di, bit hi);
    int nv;
    bit set, clr;
    v = vi; m = MW'(mi); we = wi; wa = 2'(ai); wd = 8'(di); hook = hi;
    @(posedge clk);
    nv  = shape(mi, r_ctrl[2]);
    set = vi && ((nv < 0) != (r_volt < 0));
    clr = wi && ai == 1 && di[0] == 1'b0;
    if (vi) r_volt = nv;
    if (set) r_flag = 1;
    else if (clr) r_flag = 0;
    if (wi && ai == 0) r_ctrl = di & 7;
    @(negedge clk);
    cmp(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1");
    step("R9", 0, 0, 1, 0, 8'hF3, 0);         // enable+mask, upper bits dropped
    step("R2", 1, 50, 0, 0, 0, 0);
    step("R2", 1, 200, 0, 0, 0, 0);          // saturate high
    step("R5", 1, -300, 0, 0, 0, 0);         // saturate low, sign flip
    step("R2", 0, 77, 0, 0, 0, 0);           // no strobe: hold
    step("R6", 0, 0, 1, 1, 8'hFE, 0);        // clear
    step("R6", 0, 0, 1, 1, 8'h01, 0);        // write 1: no effect
    step("R5", 1, 40, 0, 0, 0, 0);           // flip to positive
    step("R6", 0, 0, 1, 1, 0, 0);
    step("R5", 1, -40, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 1, 0, 0);
    step("R3", 1, -2, 0, 0, 0, 0);           // forced 0, sign flips
    step("R3", 1, 3, 0, 0, 0, 0);
    step("R3", 1, -3, 0, 0, 0, 0);
    step("R3", 1, 4, 0, 0, 0, 0);
    step("R3", 1, -4, 0, 0, 0, 0);
    step("R6", 0, 0, 1, 1, 0, 0);
    step("R9", 0, 0, 1, 0, 7, 0);            // disable forcing
    step("R4", 1, -2, 0, 0, 0, 0);
    step("R4", 1, 1, 0, 0, 0, 0);
    step("R4", 1, 0, 0, 0, 0, 0);
    step("R4", 1, -1, 0, 0, 0, 0);
    step("R7", 1, 5, 1, 1, 0, 0);            // set beats clear
    step("R6", 1, 6, 1, 1, 0, 0);            // no flip: clear works
    step("R10", 1, 6, 0, 0, 0, 1);
    step("R10", 1, -9, 0, 0, 0, 1);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 1, 0, 1, 0);            // mask off
    step("R8", 0, 0, 1, 0, 2, 0);            // enable off
    step("R8", 0, 0, 1, 0, 3, 0);
    step("R9", 0, 0, 1, 3, 8'hFF, 0);        // unused address
    step("R9", 0, 0, 1, 0, 8'h08, 0);
    step("R3", 1, 2, 0, 0, 0, 0);
    step("R2", 1, 127, 0, 0, 0, 0);
    step("R2", 1, -128, 0, 0, 0, 0);
    step("R2", 1, 511, 0, 0, 0, 0);
    step("R2", 1, -512, 0, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule